// File: doc/BRIEF.md
# Four-Pin Bidirectional Port with Timer and Clock Overrides

This block is a small general-purpose I/O port with four pins. It sits on a simple register bus. One register latches output data. A second register holds a direction bit for each pin and, in its top bit, an enable that puts the bus clock out on pin 0. Each direction bit turns the output buffer of its pin on or off. Pin levels pass through a two-flop synchronizer before the bus reads them or the timer receives them.

Two pins can be taken over by a timer that lives elsewhere. When the timer's channel-0 edge/level select is non-zero, pin 2 becomes that channel's capture/compare pin, and the timer's own enable and value drive it. When the timer's prescaler select picks the external clock code, pin 3 becomes an input that feeds the timer clock. Software can load the data latch while a pin is still an input, so the pin drives the intended level on the first cycle its direction bit is set.

Top module: `gpio4_af_port`

## Requirements
- R1: While reset is asserted, and directly after it, all direction bits, the clock enable and the data latch are 0, every `pin_oe` bit is 0, and both registers read 0.
- R2: For a pin with no override, `pin_oe` equals its direction bit (1 = output).
- R3: A pin with no override drives its data-latch bit on `pin_out` whatever its direction. The latch can be written while the pin is an input, and that value appears on the pin in the cycle the direction bit is set.
- R4: A read of address 0x01 returns, in bits 3:0, the latched bit for each output pin and the synchronized level for each input pin. Bits 7:4 read 0.
- R5: A read of address 0x05 returns the clock enable in bit 7 and the direction bits in bits 3:0. Bits 6:4 read 0 and ignore writes.
- R6: A change on `pin_in` shows up in a register read after exactly two rising clock edges. After one edge the read still shows the old level.
- R7: While the clock enable is 1, `pin_oe[0]` is 1 and `pin_out[0]` follows `clk`. The data and direction bits of pin 0 have no effect.
- R8: While `tmr_chsel` is non-zero, `pin_oe[2]` equals `tmr_ch_oe` and `pin_out[2]` equals `tmr_ch_out`.
- R9: While `tmr_presel` equals 3'b111, pin 3 is an input (`pin_oe[3]`=0, `pin_out[3]`=0) and `tmr_extclk` carries synchronized pin 3. For any other code, `tmr_extclk` is 0.
- R10: A register changes only at the rising edge after a cycle where `bus_wr` is 1 and `bus_addr` matches that register. Other addresses read 0.
- R11: `tmr_ch_in` always carries the synchronized level of pin 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output-buffer enables |
| tmr_chsel | input | 2 | Timer channel-0 edge/level select |
| tmr_presel | input | 3 | Timer prescaler select |
| tmr_ch_oe | input | 1 | Timer channel-0 output enable |
| tmr_ch_out | input | 1 | Timer channel-0 output value |
| tmr_ch_in | output | 1 | Synchronized pin 2 to the timer |
| tmr_extclk | output | 1 | Synchronized pin 3 as timer clock |

## Verification
The hardest point to reach is the exact cycle in which a direction bit goes from 0 to 1 after a data-latch write made while the pin was an input. If the pin glitches in that cycle, the glitch lasts only one cycle and no later read shows it. The stimulus writes the latch first, checks that the buffers are still off, and then sets the direction with a write that also places ones in the unimplemented bits. The reference model compares every output on every clock, so a stray or late level on the pins cannot pass unseen. Overrides are stacked on pins whose direction bits disagree with them, which shows that the override wins.

// File: rtl/gpio4_af_pkg.sv
package gpio4_af_pkg;
   // who owns a pin's driver this cycle
   typedef enum logic [1:0] {
      SRC_PORT   = 2'd0,
      SRC_CLKOUT = 2'd1,
      SRC_TMR_CH = 2'd2,
      SRC_TMR_IN = 2'd3
   } pin_src_e;

   typedef struct packed {
      logic oe;
      logic out;
   } pin_drv_t;
endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
   parameter int NPINS  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] raw,
   output logic [NPINS-1:0] synced
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync_bank: STAGES must be at least 2");
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2:0], raw[i]};
      end
      assign synced[i] = sh_q[STAGES-1];
   end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int              NPINS     = 4,
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 8,
   parameter int              CKEN_BIT  = 7,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 'h01,
   parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NPINS-1:0]  sync_lvl,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NPINS-1:0]  dat_q,
   output logic [NPINS-1:0]  dir_q,
   output logic              cken_q
);
   if (CKEN_BIT < NPINS || CKEN_BIT >= DATA_W) begin : g_bad_cken
      $error("gpio_port_regs: CKEN_BIT must sit above the pins and inside the word");
   end
   if (DATA_ADDR == DIR_ADDR) begin : g_bad_addr
      $error("gpio_port_regs: register addresses collide");
   end

   logic            hit_dat, hit_dir;
   logic [NPINS-1:0] rd_port;

   assign hit_dat = (bus_addr == DATA_ADDR);
   assign hit_dir = (bus_addr == DIR_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q  <= '0;
         dir_q  <= '0;
         cken_q <= 1'b0;
      end else if (bus_wr) begin
         if (hit_dat) dat_q <= bus_wdata[NPINS-1:0];
         if (hit_dir) begin
            dir_q  <= bus_wdata[NPINS-1:0];
            cken_q <= bus_wdata[CKEN_BIT];
         end
      end
   end

   // outputs read back the latch, inputs read the synchronized pad
   assign rd_port = (dir_q & dat_q) | (~dir_q & sync_lvl);

   always_comb begin
      bus_rdata = '0;
      if (hit_dat) begin
         bus_rdata[NPINS-1:0] = rd_port;
      end else if (hit_dir) begin
         bus_rdata[NPINS-1:0] = dir_q;
         bus_rdata[CKEN_BIT]  = cken_q;
      end
   end
endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route
   import gpio4_af_pkg::*;
#(
   parameter int          NPINS        = 4,
   parameter int          CHSEL_W      = 2,
   parameter int          PRESEL_W     = 3,
   parameter int          CLK_PIN      = 0,
   parameter int          CH_PIN       = 2,
   parameter int          EXT_PIN      = 3,
   parameter logic [PRESEL_W-1:0] EXT_CLK_CODE = '1
) (
   input  logic                clk,
   input  logic [NPINS-1:0]    dat_q,
   input  logic [NPINS-1:0]    dir_q,
   input  logic                cken_q,
   input  logic [NPINS-1:0]    sync_lvl,
   input  logic [CHSEL_W-1:0]  tmr_chsel,
   input  logic [PRESEL_W-1:0] tmr_presel,
   input  logic                tmr_ch_oe,
   input  logic                tmr_ch_out,
   output logic [NPINS-1:0]    pin_out,
   output logic [NPINS-1:0]    pin_oe,
   output logic                tmr_ch_in,
   output logic                tmr_extclk
);
   if (CLK_PIN >= NPINS || CH_PIN >= NPINS || EXT_PIN >= NPINS) begin : g_bad_pin
      $error("gpio_pin_route: override pin index out of range");
   end
   if (CLK_PIN == CH_PIN || CH_PIN == EXT_PIN || CLK_PIN == EXT_PIN) begin : g_bad_share
      $error("gpio_pin_route: override pins must differ");
   end

   logic ch_take, ext_take;
   assign ch_take  = |tmr_chsel;
   assign ext_take = (tmr_presel == EXT_CLK_CODE);

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pin_src_e src;
      pin_drv_t drv;

      if (i == CLK_PIN) begin : g_clk
         assign src = cken_q ? SRC_CLKOUT : SRC_PORT;
      end else if (i == CH_PIN) begin : g_ch
         assign src = ch_take ? SRC_TMR_CH : SRC_PORT;
      end else if (i == EXT_PIN) begin : g_ext
         assign src = ext_take ? SRC_TMR_IN : SRC_PORT;
      end else begin : g_plain
         assign src = SRC_PORT;
      end

      always_comb begin
         unique case (src)
            SRC_CLKOUT: drv = '{oe: 1'b1,      out: clk};
            SRC_TMR_CH: drv = '{oe: tmr_ch_oe, out: tmr_ch_out};
            SRC_TMR_IN: drv = '{oe: 1'b0,      out: 1'b0};
            default:    drv = '{oe: dir_q[i],  out: dat_q[i]};
         endcase
      end

      assign pin_oe[i]  = drv.oe;
      assign pin_out[i] = drv.out;
   end

   assign tmr_ch_in  = sync_lvl[CH_PIN];
   assign tmr_extclk = ext_take & sync_lvl[EXT_PIN];
endmodule

// File: rtl/gpio4_af_port.sv
module gpio4_af_port #(
   parameter int NPINS        = 4,
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int CKEN_BIT     = 7,
   parameter int CHSEL_W      = 2,
   parameter int PRESEL_W     = 3,
   parameter int CLK_PIN      = 0,
   parameter int CH_PIN       = 2,
   parameter int EXT_PIN      = 3,
   parameter logic [ADDR_W-1:0]   DATA_ADDR    = 'h01,
   parameter logic [ADDR_W-1:0]   DIR_ADDR     = 'h05,
   parameter logic [PRESEL_W-1:0] EXT_CLK_CODE = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NPINS-1:0]    pin_in,
   output logic [NPINS-1:0]    pin_out,
   output logic [NPINS-1:0]    pin_oe,
   input  logic [CHSEL_W-1:0]  tmr_chsel,
   input  logic [PRESEL_W-1:0] tmr_presel,
   input  logic                tmr_ch_oe,
   input  logic                tmr_ch_out,
   output logic                tmr_ch_in,
   output logic                tmr_extclk
);
   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpio4_af_port: NPINS must fit in the data word");
   end

   logic [NPINS-1:0] sync_lvl;
   logic [NPINS-1:0] dat_q;
   logic [NPINS-1:0] dir_q;
   logic             cken_q;

   gpio_sync_bank #(
      .NPINS (NPINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (pin_in),
      .synced(sync_lvl)
   );

   gpio_port_regs #(
      .NPINS    (NPINS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CKEN_BIT (CKEN_BIT),
      .DATA_ADDR(DATA_ADDR),
      .DIR_ADDR (DIR_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .sync_lvl (sync_lvl),
      .bus_rdata(bus_rdata),
      .dat_q    (dat_q),
      .dir_q    (dir_q),
      .cken_q   (cken_q)
   );

   gpio_pin_route #(
      .NPINS       (NPINS),
      .CHSEL_W     (CHSEL_W),
      .PRESEL_W    (PRESEL_W),
      .CLK_PIN     (CLK_PIN),
      .CH_PIN      (CH_PIN),
      .EXT_PIN     (EXT_PIN),
      .EXT_CLK_CODE(EXT_CLK_CODE)
   ) u_route (
      .clk       (clk),
      .dat_q     (dat_q),
      .dir_q     (dir_q),
      .cken_q    (cken_q),
      .sync_lvl  (sync_lvl),
      .tmr_chsel (tmr_chsel),
      .tmr_presel(tmr_presel),
      .tmr_ch_oe (tmr_ch_oe),
      .tmr_ch_out(tmr_ch_out),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .tmr_ch_in (tmr_ch_in),
      .tmr_extclk(tmr_extclk)
   );
endmodule

// File: rtl/gpio4_af_port_chk.sv
module gpio4_af_port_chk #(
   parameter int NPINS    = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int CKEN_BIT = 7,
   parameter int CHSEL_W  = 2,
   parameter int PRESEL_W = 3,
   parameter int CLK_PIN  = 0,
   parameter int CH_PIN   = 2,
   parameter int EXT_PIN  = 3,
   parameter logic [ADDR_W-1:0]   DATA_ADDR    = 'h01,
   parameter logic [ADDR_W-1:0]   DIR_ADDR     = 'h05,
   parameter logic [PRESEL_W-1:0] EXT_CLK_CODE = '1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NPINS-1:0]    pin_oe,
   input logic [NPINS-1:0]    pin_out,
   input logic [CHSEL_W-1:0]  tmr_chsel,
   input logic [PRESEL_W-1:0] tmr_presel,
   input logic                tmr_ch_oe,
   input logic                tmr_ch_out,
   input logic [NPINS-1:0]    dat_q,
   input logic [NPINS-1:0]    dir_q,
   input logic                cken_q
);
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (dir_q == '0 && !cken_q && pin_oe == '0)
            else $error("reset state not clear");
      end
   end

   assert_dir_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == DIR_ADDR) |-> (bus_rdata[CKEN_BIT-1:NPINS] == '0));

   assert_data_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_ADDR) |=> (dat_q == $past(bus_wdata[NPINS-1:0])));

   assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == DIR_ADDR) |=> ($stable(dir_q) && $stable(cken_q)));

   assert_clkout_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cken_q |-> pin_oe[CLK_PIN]);

   assert_chan_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_chsel != '0) |-> (pin_oe[CH_PIN] == tmr_ch_oe && pin_out[CH_PIN] == tmr_ch_out));

   assert_extclk_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_presel == EXT_CLK_CODE) |-> !pin_oe[EXT_PIN]);
endmodule

bind gpio4_af_port gpio4_af_port_chk #(
   .NPINS       (NPINS),
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .CKEN_BIT    (CKEN_BIT),
   .CHSEL_W     (CHSEL_W),
   .PRESEL_W    (PRESEL_W),
   .CLK_PIN     (CLK_PIN),
   .CH_PIN      (CH_PIN),
   .EXT_PIN     (EXT_PIN),
   .DATA_ADDR   (DATA_ADDR),
   .DIR_ADDR    (DIR_ADDR),
   .EXT_CLK_CODE(EXT_CLK_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out),
   .tmr_chsel (tmr_chsel),
   .tmr_presel(tmr_presel),
   .tmr_ch_oe (tmr_ch_oe),
   .tmr_ch_out(tmr_ch_out),
   .dat_q     (dat_q),
   .dir_q     (dir_q),
   .cken_q    (cken_q)
);

// File: tb/gpio4_af_port_tb.sv
`timescale 1ns/1ps
module gpio4_af_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] pin_in = '0;
   logic [3:0] pin_out, pin_oe;
   logic [1:0] tmr_chsel = '0;
   logic [2:0] tmr_presel = '0;
   logic       tmr_ch_oe = 1'b0, tmr_ch_out = 1'b0;
   logic       tmr_ch_in, tmr_extclk;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio4_af_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .tmr_chsel(tmr_chsel),
      .tmr_presel(tmr_presel), .tmr_ch_oe(tmr_ch_oe), .tmr_ch_out(tmr_ch_out),
      .tmr_ch_in(tmr_ch_in), .tmr_extclk(tmr_extclk)
   );

   // behavioural reference state
   logic [3:0] m_dat, m_dir, m_s1, m_s2;
   logic       m_cken;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dat <= '0; m_dir <= '0; m_cken <= 1'b0; m_s1 <= '0; m_s2 <= '0;
      end else begin
         if (bus_wr && bus_addr == 8'h01) m_dat <= bus_wdata[3:0];
         if (bus_wr && bus_addr == 8'h05) begin
            m_dir  <= bus_wdata[3:0];
            m_cken <= bus_wdata[7];
         end
         m_s1 <= pin_in;
         m_s2 <= m_s1;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every output on every falling edge (clk is 0 here)
   always @(negedge clk) begin
      if (!done) begin
         logic [3:0] e_oe, e_out;
         logic [7:0] e_rd;
         string      rtag;
         e_oe  = m_dir;
         e_out = m_dat;
         if (m_cken)            begin e_oe[0] = 1'b1;      e_out[0] = 1'b0;       end
         if (tmr_chsel != 2'b0) begin e_oe[2] = tmr_ch_oe; e_out[2] = tmr_ch_out; end
         if (tmr_presel == 3'b111) begin e_oe[3] = 1'b0;   e_out[3] = 1'b0;       end
         if (bus_addr == 8'h01) begin
            e_rd = {4'b0, (m_dir & m_dat) | (~m_dir & m_s2)}; rtag = "R4";
         end else if (bus_addr == 8'h05) begin
            e_rd = {m_cken, 3'b0, m_dir}; rtag = "R5";
         end else begin
            e_rd = 8'h00; rtag = "R10";
         end
         check("R2", 32'(pin_oe), 32'(e_oe));
         check("R3", 32'(pin_out), 32'(e_out));
         check(rtag, 32'(bus_rdata), 32'(e_rd));
         check("R11", 32'(tmr_ch_in), 32'(m_s2[2]));
         check("R9", 32'(tmr_extclk), 32'((tmr_presel == 3'b111) & m_s2[3]));
      end
   end

   task automatic step();
      @(posedge clk);
      #4;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(); step(); step();
      // R1 while reset is held
      bus_addr = 8'h05; #1;
      check("R1", 32'(pin_oe), 32'h0);
      check("R1", 32'(bus_rdata), 32'h0);
      rst_n = 1'b1;
      step();
      bus_addr = 8'h01; #1;
      check("R1", 32'(bus_rdata), 32'h0);

      // R3: latch while input, then turn buffers on; bits 6:4 written as ones
      wr(8'h01, 8'hFA);
      check("R3", 32'(pin_oe), 32'h0);
      wr(8'h05, 8'h7F);
      check("R2", 32'(pin_oe), 32'hF);
      check("R3", 32'(pin_out), 32'hA);
      bus_addr = 8'h05; #1;
      check("R5", 32'(bus_rdata), 32'h0F);

      // R6: two-edge synchronizer latency
      wr(8'h05, 8'h00);
      bus_addr = 8'h01;
      pin_in = 4'b0110;
      step();
      check("R6", 32'(bus_rdata), 32'h0);
      step();
      check("R6", 32'(bus_rdata), 32'h6);
      check("R11", 32'(tmr_ch_in), 32'h1);

      // R4: mixed directions, latch A, pads 0110
      wr(8'h05, 8'h03);
      bus_addr = 8'h01; #1;
      check("R4", 32'(bus_rdata), 32'h6);

      // R7: clock out on pin 0 with its direction bit clear
      wr(8'h05, 8'h80);
      check("R7", 32'(pin_oe), 32'h1);
      check("R7", 32'(pin_out[0]), 32'h1);
      @(negedge clk); #1;
      check("R7", 32'(pin_out[0]), 32'h0);
      step();

      // R8: timer owns pin 2
      wr(8'h05, 8'h00);
      tmr_chsel = 2'b10; tmr_ch_oe = 1'b1; tmr_ch_out = 1'b1; #1;
      check("R8", 32'(pin_oe), 32'h4);
      check("R8", 32'(pin_out[2]), 32'h1);
      tmr_ch_out = 1'b0; #1;
      check("R8", 32'(pin_out[2]), 32'h0);
      tmr_chsel = 2'b00; step();
      check("R8", 32'(pin_oe[2]), 32'h0);

      // R9: pin 3 as timer clock, direction bit set
      wr(8'h05, 8'h0F);
      tmr_presel = 3'b111; pin_in = 4'b1000;
      step(); step();
      check("R9", 32'(pin_oe[3]), 32'h0);
      check("R9", 32'(tmr_extclk), 32'h1);
      tmr_presel = 3'b011; #1;
      check("R9", 32'(tmr_extclk), 32'h0);
      check("R9", 32'(pin_oe[3]), 32'h1);

      // R10: unmatched address and missing strobe change nothing
      wr(8'h02, 8'h05);
      check("R10", 32'(pin_out), 32'hA);
      bus_addr = 8'h02; #1;
      check("R10", 32'(bus_rdata), 32'h0);
      bus_addr = 8'h01; bus_wdata = 8'h00;
      step();
      check("R10", 32'(pin_out), 32'hA);

      step(); step();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule